// File: doc/BRIEF.md
# External Asynchronous Memory Bus Controller

This block sits between a 32-bit internal request port and an external asynchronous memory bus whose data path is 16 bits wide. Each internal request carries an address, a transfer size and, for writes, data. The block decodes the address against a small set of chip-select regions and picks the region to use. It then splits the request into one, two or four external cycles. During these cycles it drives the external address, one chip-select line, the read strobe, two write strobes and two byte-enable lines. When the access is finished it returns a single-cycle done pulse, the read data and an error flag.

Each region has its own 32-bit configuration word, written through an APB-style register port and readable through the same port. The word sets the region's address window, whether the region is 8 or 16 bits wide and how many wait states it uses. It also selects two options. One pairs two byte-wide devices so that they act as one 16-bit device, with a separate write strobe per byte lane. The other is an early-read timing that drops the setup cycle before the read strobe.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset every configuration word reads as zero, so all regions are disabled. An APB write (psel, penable and pwrite all high) to paddr[3:2] = n stores the 32-bit word for region n, and an APB read of the same address returns it.
- R2: Configuration word layout:
  - Bits [31:16] hold the base.
  - Bits [15:8] hold the size mask.
  - Bit 7 enables the region.
  - Bit 6 selects 16-bit width (0 means 8-bit).
  - Bit 5 selects the paired byte-device mode.
  - Bit 4 selects early read.
  - Bits [2:0] hold the wait-state count.
- R3: A region matches when three conditions hold: the region is enabled, address bits [31:24] equal base bits [15:8], and address bits [23:16] equal base bits [7:0] in every position where the mask bit is 1. When several regions match, the lowest-numbered region wins.
- R4: A request that matches no region completes with a done pulse in the cycle after acceptance. It returns error = 1 and read data 0, and it asserts no chip select.
- R5: On a 16-bit region, a word access uses two external cycles at byte addresses A and A+2, low half first. A byte or halfword access uses one external cycle.
- R6: On an 8-bit region, a word access uses four external cycles at A, A+1, A+2 and A+3. A halfword access uses two cycles. Data always travels on the low lane ext_dout/ext_din[7:0].
- R7: req_size encodes the transfer size: 0 = byte, 1 = halfword, 2 = word. Read data and write data are right-justified, little-endian.
- R8: In standard timing, each external cycle is one setup cycle with both strobes high, followed by (wait states + 1) cycles with the strobe low.
- R9: With early read, a read asserts ext_rd_n from the first cycle of each external cycle and holds it low for (wait states + 1) cycles, with no setup cycle. Writes to such a region keep standard timing.
- R10: The region's chip-select line stays low, and only that line, for every cycle of a multi-cycle access. It rises in the done cycle.
- R11: Byte enables are active low:
  - For a byte access on a 16-bit region, ext_be_n is 2'b10 when A[0] is 0 and 2'b01 when A[0] is 1.
  - For a halfword or word access on a 16-bit region, ext_be_n is 2'b00.
  - On an 8-bit region, ext_be_n is always 2'b10.
- R12: Write strobes in normal mode: only ext_we_n[0] pulses, and the byte enables select the lanes.
- R13: Write strobes in paired byte-device mode: ext_we_n[k] pulses only for the lanes whose byte enable is low.
- R14: req_done is high for exactly one cycle per accepted request. The cycle count from acceptance to done equals the total number of external-bus cycles, plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| apb_psel | input | 1 | Register port select |
| apb_penable | input | 1 | Register port access phase |
| apb_pwrite | input | 1 | Register port write |
| apb_paddr | input | 4 | Register port byte address |
| apb_pwdata | input | 32 | Register port write data |
| apb_prdata | output | 32 | Register port read data |
| req_valid | input | 1 | Internal request valid, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Request byte address, naturally aligned |
| req_wdata | input | 32 | Right-justified write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Right-justified read data, valid with done |
| req_err | output | 1 | No region matched, valid with done |
| ext_addr | output | 24 | External byte address |
| ext_cs_n | output | 4 | Chip selects, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 2 | Write strobes per lane, active low |
| ext_be_n | output | 2 | Byte enables per lane, active low |
| ext_dout | output | 16 | Write data to the external bus |
| ext_doe | output | 1 | Drive enable for ext_dout |
| ext_din | input | 16 | Read data from the external bus |

## Verification
The bench builds the block with its default of four regions and a 24-bit external address. It programs each region with a different combination of width, wait states, paired mode, early read and mask. As a result, one run exercises 16-bit standard timing with two wait states, 8-bit width with one wait state, paired byte devices with zero wait states, and early read with three wait states under a partial mask. With four regions, the bench can also make two regions overlap to test priority. It can disable a region to show a miss, and it can place an address that passes the fixed high byte but fails the mask.

// File: rtl/ebc_pkg.sv
// Package: shared types for the external bus controller.
// Assumes the 32-bit configuration word layout given in the brief.
package ebc_pkg;

    // Per-region configuration word, bit 31 first.
    typedef struct packed {
        logic [15:0] base;
        logic [7:0]  mask;
        logic        en;
        logic        w16;
        logic        dual8;
        logic        early;
        logic        spare;
        logic [2:0]  ws;
    } region_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/ebc_cfg_regs.sv
// Configuration register file: one 32-bit word per chip-select region.
// Written and read through an APB-style port. Word index is paddr[IDX_W+1:2].
// Assumes paddr is wide enough to hold the index plus two byte-offset bits.
module ebc_cfg_regs #(
    parameter int NREG    = 4,
    parameter int PADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [PADDR_W-1:0]     paddr,
    input  logic [31:0]            pwdata,
    output logic [31:0]            prdata,
    output logic [NREG-1:0][31:0]  cfg_words
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [IDX_W-1:0] idx;
    logic             wr_en;

    assign idx   = paddr[IDX_W+1:2];
    assign wr_en = psel && penable && pwrite;

    // One register per region; cleared by reset, loaded on a matching write.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_words[g] <= '0;
            else if (wr_en && (32'(idx) == g))
                cfg_words[g] <= pwdata;
        end
    end

    // Read mux: selected word, zero for unused indices.
    always_comb begin
        prdata = '0;
        for (int i = 0; i < NREG; i++)
            if (32'(idx) == i) prdata = cfg_words[i];
    end

endmodule

// File: rtl/ebc_decode.sv
// Region decoder: compares the request address with every enabled region
// and picks the lowest-numbered match. Purely combinational.
module ebc_decode #(
    parameter int NREG = 4
) (
    input  logic [31:0]                 addr,
    input  logic [NREG-1:0][31:0]       cfg_words,
    output logic                        hit,
    output logic [$clog2(NREG)-1:0]     hit_idx,
    output ebc_pkg::region_cfg_t        hit_cfg
);
    import ebc_pkg::*;

    logic [NREG-1:0] match;

    // Per-region window compare: fixed top byte, masked second byte.
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        region_cfg_t c;
        assign c = region_cfg_t'(cfg_words[g]);
        assign match[g] = c.en
                       && (addr[31:24] == c.base[15:8])
                       && (((addr[23:16] ^ c.base[7:0]) & c.mask) == 8'h00);
    end

    // Priority pick: scanning downward lets the lowest index win.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_cfg = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = i[$clog2(NREG)-1:0];
                hit_cfg = region_cfg_t'(cfg_words[i]);
            end
        end
    end

endmodule

// File: rtl/ebc_seq.sv
// Access sequencer: accepts one internal request, splits it into external
// cycles by region width and size, times setup and strobe phases from the
// region's wait states, collects read data and raises a one-cycle done.
// Assumes naturally aligned addresses and req_valid held until done.
module ebc_seq #(
    parameter int NREG   = 4,
    parameter int EXT_AW = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [1:0]               req_size,
    input  logic [31:0]              req_addr,
    input  logic [31:0]              req_wdata,
    input  logic                     hit,
    input  logic [$clog2(NREG)-1:0]  hit_idx,
    input  ebc_pkg::region_cfg_t     hit_cfg,
    output logic                     req_done,
    output logic [31:0]              req_rdata,
    output logic                     req_err,
    output logic [EXT_AW-1:0]        ext_addr,
    output logic [NREG-1:0]          ext_cs_n,
    output logic                     ext_rd_n,
    output logic [1:0]               ext_we_n,
    output logic [1:0]               ext_be_n,
    output logic [15:0]              ext_dout,
    output logic                     ext_doe,
    input  logic [15:0]              ext_din
);
    import ebc_pkg::*;

    localparam int IDX_W = $clog2(NREG);

    seq_state_e         state;
    region_cfg_t        cur;
    logic [IDX_W-1:0]   cur_idx;
    logic               wr;
    logic [1:0]         size;
    logic [EXT_AW-1:0]  base_addr;
    logic [31:0]        wdata;
    logic [1:0]         beat;
    logic [1:0]         last_beat;
    logic [2:0]         cnt;
    logic [31:0]        rdata;
    logic               err;

    logic [1:0]         new_last;
    logic [4:0]         sh;
    logic               active;
    logic               skip_setup;
    logic [15:0]        lane_val;
    logic [31:0]        bdata;

    // Number of external cycles minus one for the incoming request.
    always_comb begin
        if (hit_cfg.w16)
            new_last = req_size[1] ? 2'd1 : 2'd0;
        else if (req_size == SZ_BYTE)
            new_last = 2'd0;
        else if (req_size == SZ_HALF)
            new_last = 2'd1;
        else
            new_last = 2'd3;
    end

    assign sh         = cur.w16 ? {beat[0], 4'b0000} : {beat, 3'b000};
    assign active     = (state == ST_SETUP) || (state == ST_STROBE);
    assign skip_setup = cur.early && !wr;

    // Read lane extraction for the current external cycle.
    always_comb begin
        if (!cur.w16)
            lane_val = {8'h00, ext_din[7:0]};
        else if (size == SZ_BYTE)
            lane_val = {8'h00, base_addr[0] ? ext_din[15:8] : ext_din[7:0]};
        else
            lane_val = ext_din;
    end

    // Main state machine and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur       <= '0;
            cur_idx   <= '0;
            wr        <= 1'b0;
            size      <= '0;
            base_addr <= '0;
            wdata     <= '0;
            beat      <= '0;
            last_beat <= '0;
            cnt       <= '0;
            rdata     <= '0;
            err       <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr        <= req_write;
                        size      <= req_size;
                        base_addr <= req_addr[EXT_AW-1:0];
                        wdata     <= req_wdata;
                        rdata     <= '0;
                        beat      <= '0;
                        if (!hit) begin
                            err   <= 1'b1;
                            cur   <= '0;
                            state <= ST_DONE;
                        end else begin
                            err       <= 1'b0;
                            cur       <= hit_cfg;
                            cur_idx   <= hit_idx;
                            last_beat <= new_last;
                            cnt       <= hit_cfg.ws;
                            state     <= (hit_cfg.early && !req_write) ? ST_STROBE : ST_SETUP;
                        end
                    end
                end
                ST_SETUP: begin
                    cnt   <= cur.ws;
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (cnt == 3'd0) begin
                        if (!wr) rdata <= rdata | (32'(lane_val) << sh);
                        if (beat == last_beat) begin
                            state <= ST_DONE;
                        end else begin
                            beat  <= beat + 2'd1;
                            cnt   <= cur.ws;
                            state <= skip_setup ? ST_STROBE : ST_SETUP;
                        end
                    end else begin
                        cnt <= cnt - 3'd1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Internal-side results.
    assign req_done  = (state == ST_DONE);
    assign req_rdata = rdata;
    assign req_err   = err;

    // External address: base plus beat offset scaled by lane count.
    assign ext_addr = base_addr + (cur.w16 ? EXT_AW'({beat, 1'b0}) : EXT_AW'(beat));

    // Chip selects: the latched region's line for the whole access.
    always_comb begin
        ext_cs_n = '1;
        if (active) ext_cs_n[cur_idx] = 1'b0;
    end

    // Byte enables from width, size and address bit 0.
    always_comb begin
        if (!active)
            ext_be_n = 2'b11;
        else if (!cur.w16)
            ext_be_n = 2'b10;
        else if (size == SZ_BYTE)
            ext_be_n = base_addr[0] ? 2'b01 : 2'b10;
        else
            ext_be_n = 2'b00;
    end

    // Strobes: read on rd_n; writes on lane 0 only unless paired mode.
    always_comb begin
        ext_rd_n = !((state == ST_STROBE) && !wr);
        if ((state == ST_STROBE) && wr)
            ext_we_n = (cur.w16 && cur.dual8) ? ext_be_n : 2'b10;
        else
            ext_we_n = 2'b11;
    end

    // Write data for the current beat, bytes duplicated on both lanes.
    assign bdata    = wdata >> sh;
    assign ext_dout = (cur.w16 && size != SZ_BYTE) ? bdata[15:0] : {bdata[7:0], bdata[7:0]};
    assign ext_doe  = active && wr;

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ext_cs_n) <= 1); // R10

    AST_CS_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(!(&ext_cs_n)) |-> req_done); // R10

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && (ext_we_n != 2'b11))); // R8

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && req_err) |-> ((&ext_cs_n) && req_rdata == 32'd0)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done); // R14

    AST_HIGH_STROBE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_we_n[1] |-> (cur.dual8 && cur.w16 && !ext_be_n[1])); // R13

endmodule

// File: rtl/ext_bus_ctrl.sv
// Top of the external bus controller: register file, region decoder and
// access sequencer. Assumes one request at a time, held until done.
module ext_bus_ctrl #(
    parameter int NREG    = 4,
    parameter int EXT_AW  = 24,
    parameter int PADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                apb_psel,
    input  logic                apb_penable,
    input  logic                apb_pwrite,
    input  logic [PADDR_W-1:0]  apb_paddr,
    input  logic [31:0]         apb_pwdata,
    output logic [31:0]         apb_prdata,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [31:0]         req_addr,
    input  logic [31:0]         req_wdata,
    output logic                req_done,
    output logic [31:0]         req_rdata,
    output logic                req_err,
    output logic [EXT_AW-1:0]   ext_addr,
    output logic [NREG-1:0]     ext_cs_n,
    output logic                ext_rd_n,
    output logic [1:0]          ext_we_n,
    output logic [1:0]          ext_be_n,
    output logic [15:0]         ext_dout,
    output logic                ext_doe,
    input  logic [15:0]         ext_din
);
    import ebc_pkg::*;

    logic [NREG-1:0][31:0]  cfg_words;
    logic                   hit;
    logic [$clog2(NREG)-1:0] hit_idx;
    region_cfg_t            hit_cfg;

    ebc_cfg_regs #(.NREG(NREG), .PADDR_W(PADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (apb_psel),
        .penable   (apb_penable),
        .pwrite    (apb_pwrite),
        .paddr     (apb_paddr),
        .pwdata    (apb_pwdata),
        .prdata    (apb_prdata),
        .cfg_words (cfg_words)
    );

    ebc_decode #(.NREG(NREG)) u_dec (
        .addr      (req_addr),
        .cfg_words (cfg_words),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_cfg   (hit_cfg)
    );

    ebc_seq #(.NREG(NREG), .EXT_AW(EXT_AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_cfg   (hit_cfg),
        .req_done  (req_done),
        .req_rdata (req_rdata),
        .req_err   (req_err),
        .ext_addr  (ext_addr),
        .ext_cs_n  (ext_cs_n),
        .ext_rd_n  (ext_rd_n),
        .ext_we_n  (ext_we_n),
        .ext_be_n  (ext_be_n),
        .ext_dout  (ext_dout),
        .ext_doe   (ext_doe),
        .ext_din   (ext_din)
    );

endmodule

// File: tb/tb_ext_bus_ctrl.sv
// Directed bench: a byte-array model of four external devices, a negedge
// bus monitor, and one task per scenario that checks its own results.
module tb_ext_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_done, req_err;
    logic [31:0] req_rdata;
    logic [23:0] ext_addr;
    logic [3:0]  ext_cs_n;
    logic        ext_rd_n, ext_doe;
    logic [1:0]  ext_we_n, ext_be_n;
    logic [15:0] ext_dout, ext_din;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    ext_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .apb_psel(psel), .apb_penable(penable), .apb_pwrite(pwrite),
        .apb_paddr(paddr), .apb_pwdata(pwdata), .apb_prdata(prdata),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata), .req_err(req_err),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_we_n(ext_we_n), .ext_be_n(ext_be_n), .ext_dout(ext_dout),
        .ext_doe(ext_doe), .ext_din(ext_din)
    );

    // Bench's own view of each region: width and paired mode.
    logic [3:0] m_w16  = 4'b1101;
    logic [3:0] m_pair = 4'b0100;
    logic [7:0] mem [4][256];

    function automatic int sel_cs(input logic [3:0] csn);
        for (int k = 0; k < 4; k++) if (!csn[k]) return k;
        return -1;
    endfunction

    // Device read model.
    always_comb begin
        int k;
        k = sel_cs(ext_cs_n);
        ext_din = 16'h0000;
        if (k >= 0) begin
            if (m_w16[k]) ext_din = {mem[k][{ext_addr[7:1], 1'b1}], mem[k][{ext_addr[7:1], 1'b0}]};
            else          ext_din = {8'h00, mem[k][ext_addr[7:0]]};
        end
    end

    // Device write model.
    always @(posedge clk) begin
        int k;
        k = sel_cs(ext_cs_n);
        if (k >= 0 && ext_we_n != 2'b11) begin
            if (!m_w16[k]) begin
                if (!ext_we_n[0]) mem[k][ext_addr[7:0]] = ext_dout[7:0];
            end else begin
                for (int l = 0; l < 2; l++) begin
                    if (m_pair[k] ? !ext_we_n[l] : (!ext_we_n[0] && !ext_be_n[l]))
                        mem[k][{ext_addr[7:1], l[0]}] = ext_dout[8*l +: 8];
                end
            end
        end
    end

    // Bus monitor.
    int          cs_cyc, rd_cyc, we0_cyc, we1_cyc, naddr, cs_falls;
    logic        rd_first, prev_cs;
    logic [1:0]  be_first;
    logic [3:0]  cs_seen;
    logic [23:0] alist [8];
    logic [23:0] last_a;

    task automatic mon_clear();
        cs_cyc = 0; rd_cyc = 0; we0_cyc = 0; we1_cyc = 0; naddr = 0; cs_falls = 0;
        rd_first = 1'b0; be_first = 2'b11; cs_seen = 4'h0; prev_cs = 1'b0;
    endtask

    always @(negedge clk) begin
        if (ext_cs_n != 4'hF) begin
            if (cs_cyc == 0) begin rd_first = !ext_rd_n; be_first = ext_be_n; end
            if (!prev_cs) cs_falls++;
            if ((cs_cyc == 0 || ext_addr != last_a) && naddr < 8) begin
                alist[naddr] = ext_addr; naddr++;
            end
            last_a = ext_addr;
            cs_seen = cs_seen | ~ext_cs_n;
            cs_cyc++;
            if (!ext_rd_n)    rd_cyc++;
            if (!ext_we_n[0]) we0_cyc++;
            if (!ext_we_n[1]) we1_cyc++;
        end
        prev_cs = (ext_cs_n != 4'hF);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = {idx, 2'b00}; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [1:0] idx, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = {idx, 2'b00};
        #1 d = prdata;
        psel = 0;
    endtask

    logic [31:0] r_data;
    logic        r_err;
    int          r_lat;

    task automatic access(input logic w, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd);
        @(negedge clk);
        mon_clear();
        req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        r_lat = 0;
        do begin
            @(negedge clk);
            r_lat++;
        end while (!req_done && r_lat < 200);
        if (r_lat >= 200) begin
            checks++; fails++;
            $display("FAIL R14: access hung, actual no done expected done");
        end
        r_data = req_rdata; r_err = req_err;
        req_valid = 0;
        @(negedge clk);
        chk("R14 done one cycle", {31'b0, req_done}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 cs idle", {28'b0, ext_cs_n}, 32'hF);
        chk("R1 strobes idle", {29'b0, ext_rd_n, ext_we_n}, 32'h7);
        chk("R14 no done", {31'b0, req_done}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            apb_rd(i[1:0], d);
            chk("R1 reset cfg zero", d, 32'd0);
        end
    endtask

    task automatic t_config();
        logic [31:0] d;
        apb_wr(2'd0, 32'h1000FFC2);
        apb_wr(2'd1, 32'h2000FF81);
        apb_wr(2'd2, 32'h3000FFE0);
        apb_wr(2'd3, 32'h4000F0D3);
        apb_rd(2'd1, d); chk("R1 readback r1", d, 32'h2000FF81);
        apb_rd(2'd3, d); chk("R1 readback r3", d, 32'h4000F0D3);
    endtask

    task automatic t_wide16();
        access(1, 2'd2, 32'h1000_0010, 32'hA1B2C3D4);
        chk("R5 beats", naddr, 2);
        chk("R5 first addr", alist[0], 24'h000010);
        chk("R5 second addr", alist[1], 24'h000012);
        chk("R8 cs cycles ws2", cs_cyc, 8);
        chk("R8 strobe cycles ws2", we0_cyc, 6);
        chk("R12 no high strobe", we1_cyc, 0);
        chk("R10 single cs fall", cs_falls, 1);
        chk("R14 latency", r_lat, 9);
        chk("R5 mem", {mem[0][8'h13], mem[0][8'h12], mem[0][8'h11], mem[0][8'h10]}, 32'hA1B2C3D4);
        access(0, 2'd2, 32'h1000_0010, 0);
        chk("R5 read word", r_data, 32'hA1B2C3D4);
        chk("R8 rd cycles", rd_cyc, 6);
        chk("R8 no early rd", {31'b0, rd_first}, 32'd0);
        chk("R11 be word", {30'b0, be_first}, 32'd0);
        chk("R4 err clear", {31'b0, r_err}, 32'd0);
    endtask

    task automatic t_narrow8();
        access(1, 2'd2, 32'h2000_0020, 32'h11223344);
        chk("R6 beats", naddr, 4);
        chk("R6 last addr", alist[3], 24'h000023);
        chk("R6 cs cycles ws1", cs_cyc, 12);
        chk("R6 strobe cycles", we0_cyc, 8);
        chk("R11 be 8-bit", {30'b0, be_first}, 32'h2);
        chk("R6 mem", {mem[1][8'h23], mem[1][8'h22], mem[1][8'h21], mem[1][8'h20]}, 32'h11223344);
        access(0, 2'd1, 32'h2000_0022, 0);
        chk("R7 half read", r_data, 32'h00001122);
        chk("R6 half beats", naddr, 2);
        access(0, 2'd0, 32'h2000_0021, 0);
        chk("R7 byte read 8", r_data, 32'h00000033);
    endtask

    task automatic t_early();
        mem[3][8'h40] = 8'h01; mem[3][8'h41] = 8'h02; mem[3][8'h42] = 8'h03; mem[3][8'h43] = 8'h04;
        access(0, 2'd2, 32'h4005_0040, 0);
        chk("R9 data", r_data, 32'h04030201);
        chk("R9 cs cycles", cs_cyc, 8);
        chk("R9 rd cycles", rd_cyc, 8);
        chk("R9 rd first cycle", {31'b0, rd_first}, 32'd1);
        chk("R14 early latency", r_lat, 9);
        access(1, 2'd2, 32'h4005_0044, 32'hCAFEF00D);
        chk("R9 write std cs", cs_cyc, 10);
        chk("R9 write strobe", we0_cyc, 8);
        chk("R9 write mem", {mem[3][8'h47], mem[3][8'h46], mem[3][8'h45], mem[3][8'h44]}, 32'hCAFEF00D);
    endtask

    task automatic t_lanes();
        mem[2][8'h04] = 8'h77;
        access(1, 2'd0, 32'h3000_0005, 32'h0000005A);
        chk("R13 high strobe", we1_cyc, 1);
        chk("R13 low quiet", we0_cyc, 0);
        chk("R11 be odd", {30'b0, be_first}, 32'h1);
        chk("R13 mem odd", {24'b0, mem[2][8'h05]}, 32'h5A);
        chk("R13 mem even kept", {24'b0, mem[2][8'h04]}, 32'h77);
        access(1, 2'd1, 32'h3000_0008, 32'h0000BEEF);
        chk("R13 half both strobes", {we1_cyc[15:0], we0_cyc[15:0]}, 32'h00010001);
        chk("R13 half mem", {mem[2][8'h09], mem[2][8'h08]}, 32'hBEEF);
        mem[0][8'h20] = 8'h99;
        access(1, 2'd0, 32'h1000_0021, 32'h0000003C);
        chk("R12 normal low strobe", we0_cyc, 3);
        chk("R12 normal no high", we1_cyc, 0);
        chk("R12 mem odd", {24'b0, mem[0][8'h21]}, 32'h3C);
        chk("R12 mem even kept", {24'b0, mem[0][8'h20]}, 32'h99);
        access(0, 2'd0, 32'h1000_0013, 0);
        chk("R7 byte read 16", r_data, 32'h000000A1);
        chk("R11 be byte odd read", {30'b0, be_first}, 32'h1);
        access(0, 2'd0, 32'h1000_0010, 0);
        chk("R11 be byte even read", {30'b0, be_first}, 32'h2);
    endtask

    task automatic t_decode();
        access(0, 2'd2, 32'h5000_0000, 0);
        chk("R4 err", {31'b0, r_err}, 32'd1);
        chk("R4 zero data", r_data, 32'd0);
        chk("R4 no cs", cs_cyc, 0);
        chk("R4 latency", r_lat, 1);
        access(0, 2'd2, 32'h4010_0000, 0);
        chk("R3 mask miss", {31'b0, r_err}, 32'd1);
        apb_wr(2'd2, 32'h1000FFE0);
        access(0, 2'd2, 32'h1000_0010, 0);
        chk("R3 priority low index", {28'b0, cs_seen}, 32'h1);
        apb_wr(2'd0, 32'h1000FF42);
        access(0, 2'd2, 32'h1000_0010, 0);
        chk("R2 disabled skipped", {28'b0, cs_seen}, 32'h4);
        apb_wr(2'd2, 32'h3000FFE0);
        access(0, 2'd2, 32'h1000_0010, 0);
        chk("R2 disabled miss", {31'b0, r_err}, 32'd1);
        apb_wr(2'd0, 32'h1000FFC2);
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) for (int a = 0; a < 256; a++) mem[k][a] = 8'h00;
        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_config();
        t_wide16();
        t_narrow8();
        t_early();
        t_lanes();
        t_decode();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule